// File: doc/BRIEF.md
# Accumulator ALU with Flag Register

This block is the arithmetic and logic stage of an accumulator-based 8-bit processor. Each cycle it takes the accumulator value, an operand byte and a 4-bit operation code. From these it produces a result byte, a write-enable for the accumulator, and the next value of a five-bit flag word. The caller fetches the operand from a register, from memory or from an immediate field before presenting it. The datapath is purely combinational.

The flag word is held in a small register inside the block. That register loads the next flag value on any clock edge where the flag strobe is high. Operations that need the incoming carry or auxiliary carry read them from this register. The result and flags therefore always follow the flags committed by earlier strobes.

The operation set covers:
- binary add and subtract, each with and without carry or borrow
- compare, which updates the flags but never writes the accumulator
- bitwise AND, OR and XOR
- accumulator complement
- set-carry
- decimal adjust after a packed-BCD addition
- four one-bit rotates, two of which pass through the carry

Top module: `acc_alu`

## Requirements
- R1: While reset is high at a clock edge, the flag register clears to 00000b.
- R2: Op code 0 (add) produces acc+opnd. Op code 1 (add with carry) produces acc+opnd+C. The carry flag takes the carry out of bit 7. AC takes the carry out of bit 3. The accumulator write-enable is 1.
- R3: Op code 2 (subtract) produces acc−opnd. Op code 3 (subtract with borrow) produces acc−opnd−C. The carry flag is the borrow out of bit 7. AC is the borrow out of the low nibble. The write-enable is 1.
- R4: Op code 4 (compare) drives the write-enable to 0 and places acc−opnd on the result. It sets flags exactly as subtract does, so carry is 1 precisely when acc is below opnd.
- R5: Op codes 5, 6 and 7 give the bitwise AND, OR and XOR of acc and opnd. They clear both carry and AC.
- R6: Flag word bit order is [4] sign, [3] zero, [2] auxiliary carry (AC), [1] parity, [0] carry. For op codes 0 to 7 and 10, the result sets sign, zero and parity as follows:
  - sign copies result bit 7
  - zero is 1 for a zero result
  - parity is 1 when the result holds an even number of ones
- R7: Op code 8 (complement) drives the bitwise inverse of acc with write-enable 1. The operand is ignored and all five flags keep their registered values.
- R8: Op code 9 (set carry) drives write-enable 0 and result equal to acc. It sets carry to 1 and leaves the other four flags unchanged.
- R9: Op code 10 (decimal adjust) adds a correction to acc.
  - The correction contains 06h if the low nibble exceeds 9 or AC is set.
  - It contains 60h if acc exceeds 99h or carry is set.
  - The new carry is 1 whenever the 60h part is applied.
  - The new AC is the carry out of bit 3 of that addition.
- R10: Op codes 11 to 14 rotate acc by one bit and change only the carry flag:
  - 11 rotates left, with bit 7 going to both bit 0 and carry.
  - 12 rotates right, with bit 0 going to both bit 7 and carry.
  - 13 rotates left through carry.
  - 14 rotates right through carry.
- R11: Op code 15 is a no-operation. It drives write-enable 0, result equal to acc, and the next flags equal to the registered flags.
- R12: On a clock edge with the strobe high, the flag register loads the next-flag output. With the strobe low it holds its value. The carry and AC inputs of every operation come from the registered flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 4 | Operation code |
| acc | input | 8 | Current accumulator value |
| opnd | input | 8 | Operand byte |
| flag_we | input | 1 | Flag register load strobe |
| result | output | 8 | Operation result |
| acc_we | output | 1 | Accumulator write-enable |
| flags_nxt | output | 5 | Next flag value {S,Z,AC,P,C} |
| flags_q | output | 5 | Registered flag value {S,Z,AC,P,C} |

## Verification
A carry-consuming operation and a flag commit can fall in the same cycle. In that cycle, the add-with-carry result must use the carry committed earlier, while the register captures the new carry the same operation produces. The bench provokes this by issuing add-with-carry with the strobe high after a carry-setting add. It then repeats the identical operation one cycle later, and judges the two results: the first must include the old carry and the second the freshly committed one. Decimal adjust and the through-carry rotates are also run directly after set-carry commits, so that the registered flags feed them in the following cycle.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int DATA_W = 8;
    localparam int NIB_W  = 4;
    localparam int FLAG_W = 5;
    localparam int OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBB = 4'd3,
        OP_CMP = 4'd4,
        OP_AND = 4'd5,
        OP_OR  = 4'd6,
        OP_XOR = 4'd7,
        OP_CMA = 4'd8,
        OP_STC = 4'd9,
        OP_DAA = 4'd10,
        OP_RLC = 4'd11,
        OP_RRC = 4'd12,
        OP_RAL = 4'd13,
        OP_RAR = 4'd14,
        OP_NOP = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic s;
        logic z;
        logic ac;
        logic p;
        logic c;
    } flags_t;

    function automatic logic even_ones(input logic [DATA_W-1:0] v);
        return ~(^v);
    endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
    import acc_alu_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int NW = NIB_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] res,
    output logic         cout,
    output logic         aux
);
    localparam int EW = W + 1;
    localparam int NE = NW + 1;

    logic [EW-1:0] wide;
    logic [NE-1:0] low;

    always_comb begin
        if (sub) begin
            wide = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
            low  = {1'b0, a[NW-1:0]} - {1'b0, b[NW-1:0]} - {{NW{1'b0}}, cin};
        end else begin
            wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
            low  = {1'b0, a[NW-1:0]} + {1'b0, b[NW-1:0]} + {{NW{1'b0}}, cin};
        end
        res  = wide[W-1:0];
        cout = wide[W];
        aux  = low[NW];
    end
endmodule

// File: rtl/alu_bitops.sv
module alu_bitops
    import acc_alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         cout
);
    always_comb begin
        res  = a;
        cout = 1'b0;
        unique case (op)
            OP_AND: res = a & b;
            OP_OR:  res = a | b;
            OP_XOR: res = a ^ b;
            OP_CMA: res = ~a;
            OP_RLC: begin res = {a[W-2:0], a[W-1]}; cout = a[W-1]; end
            OP_RRC: begin res = {a[0], a[W-1:1]};   cout = a[0];   end
            OP_RAL: begin res = {a[W-2:0], cin};    cout = a[W-1]; end
            OP_RAR: begin res = {cin, a[W-1:1]};    cout = a[0];   end
            default: begin res = a; cout = 1'b0; end
        endcase
    end
endmodule

// File: rtl/alu_decadj.sv
module alu_decadj
    import acc_alu_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int NW = NIB_W
) (
    input  logic [W-1:0] a,
    input  logic         cy,
    input  logic         ac,
    output logic [W-1:0] res,
    output logic         cy_out,
    output logic         ac_out
);
    localparam logic [NW-1:0] DIG_MAX = NW'(9);
    localparam logic [NW-1:0] FIX     = NW'(6);
    localparam logic [W-1:0]  BYTE_MAX = {DIG_MAX, DIG_MAX};

    logic          lo_fix, hi_fix;
    logic [W-1:0]  corr;
    logic [NW:0]   low_sum;

    always_comb begin
        lo_fix  = (a[NW-1:0] > DIG_MAX) | ac;
        hi_fix  = (a > BYTE_MAX) | cy;
        corr    = {(hi_fix ? FIX : {NW{1'b0}}), (lo_fix ? FIX : {NW{1'b0}})};
        res     = a + corr;
        low_sum = {1'b0, a[NW-1:0]} + {1'b0, corr[NW-1:0]};
        ac_out  = low_sum[NW];
        cy_out  = hi_fix;
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OP_W-1:0]   op,
    input  logic [W-1:0]      acc,
    input  logic [W-1:0]      opnd,
    input  logic              flag_we,
    output logic [W-1:0]      result,
    output logic              acc_we,
    output logic [FLAG_W-1:0] flags_nxt,
    output logic [FLAG_W-1:0] flags_q
);
    alu_op_e     op_e;
    flags_t      fq, fn;
    logic        as_cin, as_sub, as_co, as_ac;
    logic [W-1:0] as_res, bo_res, da_res;
    logic        bo_co, da_co, da_ac;
    logic        szp_upd;

    assign op_e   = alu_op_e'(op);
    assign as_sub = (op_e == OP_SUB) || (op_e == OP_SBB) || (op_e == OP_CMP);
    assign as_cin = ((op_e == OP_ADC) || (op_e == OP_SBB)) ? fq.c : 1'b0;

    alu_addsub #(.W(W)) u_addsub (
        .a(acc), .b(opnd), .cin(as_cin), .sub(as_sub),
        .res(as_res), .cout(as_co), .aux(as_ac)
    );

    alu_bitops #(.W(W)) u_bitops (
        .op(op_e), .a(acc), .b(opnd), .cin(fq.c),
        .res(bo_res), .cout(bo_co)
    );

    alu_decadj #(.W(W)) u_decadj (
        .a(acc), .cy(fq.c), .ac(fq.ac),
        .res(da_res), .cy_out(da_co), .ac_out(da_ac)
    );

    always_comb begin
        fn      = fq;
        result  = acc;
        acc_we  = 1'b1;
        szp_upd = 1'b0;
        unique case (op_e)
            OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_CMP: begin
                result  = as_res;
                fn.c    = as_co;
                fn.ac   = as_ac;
                szp_upd = 1'b1;
                acc_we  = (op_e != OP_CMP);
            end
            OP_AND, OP_OR, OP_XOR: begin
                result  = bo_res;
                fn.c    = 1'b0;
                fn.ac   = 1'b0;
                szp_upd = 1'b1;
            end
            OP_CMA: result = bo_res;
            OP_STC: begin
                acc_we = 1'b0;
                fn.c   = 1'b1;
            end
            OP_DAA: begin
                result  = da_res;
                fn.c    = da_co;
                fn.ac   = da_ac;
                szp_upd = 1'b1;
            end
            OP_RLC, OP_RRC, OP_RAL, OP_RAR: begin
                result = bo_res;
                fn.c   = bo_co;
            end
            default: acc_we = 1'b0;
        endcase
        if (szp_upd) begin
            fn.s = result[W-1];
            fn.z = (result == '0);
            fn.p = even_ones(result);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            fq <= '0;
        else if (flag_we)
            fq <= fn;
    end

    assign flags_nxt = fn;
    assign flags_q   = fq;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
    import acc_alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input logic              clk,
    input logic              rst,
    input logic [OP_W-1:0]   op,
    input logic [W-1:0]      acc,
    input logic [W-1:0]      opnd,
    input logic              flag_we,
    input logic [W-1:0]      result,
    input logic              acc_we,
    input logic [FLAG_W-1:0] flags_nxt,
    input logic [FLAG_W-1:0] flags_q
);
    a_r12_capture: assert property (@(posedge clk) disable iff (rst)
        flag_we |=> (flags_q == $past(flags_nxt)));

    a_r12_hold: assert property (@(posedge clk) disable iff (rst)
        !flag_we |=> $stable(flags_q));

    a_r4_cmp_nowrite: assert property (@(posedge clk) disable iff (rst)
        (op == 4'd4) |-> (!acc_we && (flags_nxt[0] == (acc < opnd))));

    a_r5_logic_clear: assert property (@(posedge clk) disable iff (rst)
        (op >= 4'd5 && op <= 4'd7) |-> (flags_nxt[0] == 1'b0 && flags_nxt[2] == 1'b0));

    a_r10_rot_keep: assert property (@(posedge clk) disable iff (rst)
        (op >= 4'd11 && op <= 4'd14) |-> (flags_nxt[4:1] == flags_q[4:1]));

    a_r6_zero: assert property (@(posedge clk) disable iff (rst)
        (op <= 4'd7 || op == 4'd10) |-> (flags_nxt[3] == (result == '0)));

    a_r2_sum: assert property (@(posedge clk) disable iff (rst)
        (op == 4'd0) |-> ({flags_nxt[0], result} == ({1'b0, acc} + {1'b0, opnd})));
endmodule

bind acc_alu acc_alu_chk #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .op(op), .acc(acc), .opnd(opnd),
    .flag_we(flag_we), .result(result), .acc_we(acc_we),
    .flags_nxt(flags_nxt), .flags_q(flags_q)
);

// File: tb/acc_alu_tb.sv
module acc_alu_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] op = 4'd15;
    logic [7:0] acc = '0;
    logic [7:0] opnd = '0;
    logic       flag_we = 1'b0;
    logic [7:0] result;
    logic       acc_we;
    logic [4:0] flags_nxt, flags_q;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    acc_alu u_dut (
        .clk(clk), .rst(rst), .op(op), .acc(acc), .opnd(opnd),
        .flag_we(flag_we), .result(result), .acc_we(acc_we),
        .flags_nxt(flags_nxt), .flags_q(flags_q)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [3:0] o, input logic [7:0] a, input logic [7:0] b, input logic we);
        @(negedge clk);
        op = o; acc = a; opnd = b; flag_we = we;
        #1;
    endtask

    task automatic out(input string req, input logic we, input logic [4:0] fl, input logic [7:0] res);
        chk(req, {2'b0, acc_we, flags_nxt, result}, {2'b0, we, fl, res});
    endtask

    task automatic fq(input string req, input logic [4:0] fl);
        apply(4'd15, 8'h00, 8'h00, 1'b0);
        chk(req, {11'b0, flags_q}, {11'b0, fl});
    endtask

    task automatic t_reset;
        chk("R1 flags after reset", {11'b0, flags_q}, 16'h0000);
    endtask

    task automatic t_add;
        apply(4'd0, 8'h06, 8'h08, 1'b0); out("R2 add 06+08", 1'b1, 5'b00000, 8'h0E);
        apply(4'd0, 8'h88, 8'h88, 1'b1); out("R2 add 88+88 carry/aux", 1'b1, 5'b00101, 8'h10);
        fq("R12 commit after add", 5'b00101);
    endtask

    task automatic t_adc_strobe;
        apply(4'd1, 8'h50, 8'h20, 1'b1); out("R2 adc uses old carry", 1'b1, 5'b00010, 8'h71);
        apply(4'd1, 8'h50, 8'h20, 1'b0); out("R12 adc uses new carry", 1'b1, 5'b00000, 8'h70);
        chk("R12 flags captured", {11'b0, flags_q}, 16'h0002);
    endtask

    task automatic t_sub;
        apply(4'd9, 8'h33, 8'h77, 1'b1); out("R8 stc", 1'b0, 5'b00011, 8'h33);
        apply(4'd3, 8'h50, 8'h20, 1'b0); out("R3 sbb 50-20-1", 1'b1, 5'b00100, 8'h2F);
        apply(4'd2, 8'h50, 8'h10, 1'b0); out("R3 sub ignores carry", 1'b1, 5'b00000, 8'h40);
        apply(4'd2, 8'h00, 8'h01, 1'b0); out("R3 sub borrow, R6 sign", 1'b1, 5'b10111, 8'hFF);
    endtask

    task automatic t_cmp;
        apply(4'd4, 8'hB8, 8'hB9, 1'b0); out("R4 cmp less", 1'b0, 5'b10111, 8'hFF);
        apply(4'd4, 8'h42, 8'h42, 1'b0); out("R4 cmp equal", 1'b0, 5'b01010, 8'h00);
        apply(4'd4, 8'hC0, 8'h10, 1'b0); out("R4 cmp greater", 1'b0, 5'b10000, 8'hB0);
    endtask

    task automatic t_logic;
        apply(4'd5, 8'hAA, 8'h0F, 1'b0); out("R5 and clears carry", 1'b1, 5'b00010, 8'h0A);
        apply(4'd6, 8'h55, 8'hB3, 1'b0); out("R5 or", 1'b1, 5'b10000, 8'hF7);
        apply(4'd7, 8'hB3, 8'h39, 1'b0); out("R5 xor", 1'b1, 5'b10000, 8'h8A);
        apply(4'd7, 8'h5A, 8'h5A, 1'b0); out("R6 xor zero", 1'b1, 5'b01010, 8'h00);
    endtask

    task automatic t_cma_stc;
        apply(4'd8, 8'h88, 8'h12, 1'b0); out("R7 cma keeps flags", 1'b1, 5'b00011, 8'h77);
        apply(4'd5, 8'h00, 8'h00, 1'b1); out("R6 and zero", 1'b1, 5'b01010, 8'h00);
        apply(4'd9, 8'h5A, 8'h00, 1'b0); out("R8 stc keeps others", 1'b0, 5'b01011, 8'h5A);
    endtask

    task automatic t_daa;
        apply(4'd5, 8'hFF, 8'hFF, 1'b1); out("R6 and ff", 1'b1, 5'b10010, 8'hFF);
        apply(4'd10, 8'h4B, 8'h00, 1'b0); out("R9 daa low fix", 1'b1, 5'b00100, 8'h51);
        apply(4'd10, 8'hA5, 8'h00, 1'b0); out("R9 daa high fix", 1'b1, 5'b00011, 8'h05);
        apply(4'd10, 8'h9A, 8'h00, 1'b0); out("R9 daa both to zero", 1'b1, 5'b01111, 8'h00);
        apply(4'd0, 8'h0F, 8'h01, 1'b1); out("R2 add aux", 1'b1, 5'b00100, 8'h10);
        apply(4'd10, 8'h12, 8'h00, 1'b0); out("R9 daa aux fix", 1'b1, 5'b00010, 8'h18);
        apply(4'd9, 8'h00, 8'h00, 1'b1);
        apply(4'd10, 8'h12, 8'h00, 1'b0); out("R9 daa carry and aux", 1'b1, 5'b00011, 8'h78);
    endtask

    task automatic t_rotate;
        apply(4'd5, 8'hFF, 8'hFF, 1'b1);
        apply(4'd11, 8'h57, 8'h00, 1'b0); out("R10 rlc 57", 1'b1, 5'b10010, 8'hAE);
        apply(4'd11, 8'h80, 8'h00, 1'b0); out("R10 rlc 80", 1'b1, 5'b10011, 8'h01);
        apply(4'd12, 8'h01, 8'h00, 1'b0); out("R10 rrc 01", 1'b1, 5'b10011, 8'h80);
        apply(4'd14, 8'hA3, 8'h00, 1'b0); out("R10 rar A3 c0", 1'b1, 5'b10011, 8'h51);
        apply(4'd13, 8'h57, 8'h00, 1'b0); out("R10 ral 57 c0", 1'b1, 5'b10010, 8'hAE);
        apply(4'd9, 8'h00, 8'h00, 1'b1);
        apply(4'd13, 8'h57, 8'h00, 1'b0); out("R10 ral 57 c1", 1'b1, 5'b10010, 8'hAF);
        apply(4'd14, 8'h02, 8'h00, 1'b0); out("R10 rar 02 c1", 1'b1, 5'b10010, 8'h81);
        apply(4'd14, 8'hA3, 8'h00, 1'b0); out("R10 rar A3 c1", 1'b1, 5'b10011, 8'hD1);
    endtask

    task automatic t_nop_hold;
        apply(4'd15, 8'h3C, 8'hC3, 1'b1); out("R11 nop", 1'b0, 5'b10011, 8'h3C);
        apply(4'd0, 8'h88, 8'h88, 1'b0); out("R2 add no strobe", 1'b1, 5'b00101, 8'h10);
        fq("R12 hold without strobe", 5'b10011);
    endtask

    task automatic t_reset_again;
        @(negedge clk); rst = 1'b1;
        @(negedge clk); #1;
        chk("R1 flags cleared by reset", {11'b0, flags_q}, 16'h0000);
        rst = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset;
        t_add;
        t_adc_strobe;
        t_sub;
        t_cmp;
        t_logic;
        t_cma_stc;
        t_daa;
        t_rotate;
        t_nop_hold;
        t_reset_again;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule